// File: doc/BRIEF.md
# PIO Timing Converter for a Two-Drive Disk Channel

This block turns the nanosecond timing figures of a parallel disk channel's programmed-I/O transfer into clock counts for a bus running at a given frequency in MHz. Each of the two drives on the channel supplies three figures: the address setup time, the active (data strobe) time and the full cycle time. The recovery time is what remains of the cycle once setup and active time are taken out. Every figure is rounded up to whole clocks and then clamped to the range that its register field can hold.

The results are packed into three bytes that a channel controller loads into its timing registers. There is one cycle byte for each drive, holding its data and recovery counts. A shared byte holds the address setup count, which both drives must share, together with a prefetch enable bit. A drive that is flagged absent gets the shortest legal settings. The block is started with a one-cycle `start` pulse. It works through the six conversions with a single shared restoring divider, then pulses `done` for one clock while the output bytes take their new values.

Top module: `pio_timing_conv`

## Requirements
- R1: Each count equals ceil(t × f / 1000) for a time t in ns and a bus frequency f in MHz, computed as (t × f + 999) / 1000 with integer division; a product that is an exact multiple of 1000 does not round up.
- R2: The recovery time in ns is cycle − setup − active; if that difference is zero or negative, it is treated as 0 ns.
- R3: Counts are clamped: address to 1..4, data to 1..16, recovery to 2..17.
- R4: A drive whose present flag is 0 gets address 1, data 1 and recovery 2, so its cycle byte is 8'h00, whatever its timing inputs are.
- R5: The shared address count is the larger of the two drives' clamped address counts.
- R6: Each cycle byte holds data − 1 in bits 7:4 and recovery − 2 in bits 3:0.
- R7: The shared byte holds the prefetch enable input in bit 6 and address − 1 in bits 5:4; bits 7 and 3:0 are 0, because the ready-delay field is fixed at its minimum.
- R8: After a `start` pulse taken while idle, `busy` is high from the next cycle until the cycle in which `done` is high for exactly one clock. The output bytes change only in that `done` cycle and otherwise hold their values.
- R9: A `start` pulse that arrives while `busy` is high is ignored: it produces no extra `done`, and the inputs present at that moment do not affect the result.
- R10: After reset, `busy` and `done` are 0 and all three output bytes are 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to convert the current inputs |
| pfetch_en | input | 1 | Prefetch enable, copied into the shared byte |
| bus_mhz | input | 8 | Bus frequency in MHz |
| drv_present | input | 2 | Present flag for drive 1 (bit 1) and drive 0 (bit 0) |
| setup_ns0 | input | 10 | Drive 0 address setup time in ns |
| active_ns0 | input | 10 | Drive 0 active time in ns |
| cycle_ns0 | input | 10 | Drive 0 full cycle time in ns |
| setup_ns1 | input | 10 | Drive 1 address setup time in ns |
| active_ns1 | input | 10 | Drive 1 active time in ns |
| cycle_ns1 | input | 10 | Drive 1 full cycle time in ns |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse; the output bytes take new values in this cycle |
| cyc_byte0 | output | 8 | Drive 0 cycle byte |
| cyc_byte1 | output | 8 | Drive 1 cycle byte |
| misc_byte | output | 8 | Shared address setup and prefetch byte |

## Verification
The hardest situation to reach is a second `start` that lands in the middle of a running conversion while the timing inputs are being changed. Only that case shows whether the block keeps the values it latched and drops the request. The bench pulses `start`, waits a few cycles, then drives completely different timings together with another `start` pulse. It then checks that exactly one result arrives and that it matches the first request. Negative recovery differences and products that are exact multiples of 1000 are also hard to hit with standard mode timings, so the bench uses hand-picked figures to land exactly on those boundaries and on both ends of every clamp.

// File: rtl/pio_tc_pkg.sv
// Package: shared types and helpers for the PIO timing converter.
// Assumes quotients fit in 32 bits (time width + MHz width + 1 <= 32).
package pio_tc_pkg;

    // Which timing field a conversion job produces
    typedef enum logic [1:0] {
        FLD_ADDR = 2'd0,
        FLD_DATA = 2'd1,
        FLD_REC  = 2'd2
    } field_e;

    // Sequencer states of the top module
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } state_e;

    // Legal ranges of each clock-count field
    localparam int ADDR_MIN = 1;
    localparam int ADDR_MAX = 4;
    localparam int DATA_MIN = 1;
    localparam int DATA_MAX = 16;
    localparam int REC_MIN  = 2;
    localparam int REC_MAX  = 17;
    localparam int CNT_W    = 5;

    // Clamp a raw clock count into the range of the given field
    function automatic logic [CNT_W-1:0] clamp_count(input int unsigned raw, input field_e fld);
        int unsigned lo;
        int unsigned hi;
        int unsigned v;
        case (fld)
            FLD_ADDR: begin lo = ADDR_MIN; hi = ADDR_MAX; end
            FLD_DATA: begin lo = DATA_MIN; hi = DATA_MAX; end
            default:  begin lo = REC_MIN;  hi = REC_MAX;  end
        endcase
        v = raw;
        if (v < lo) v = lo;
        if (v > hi) v = hi;
        return CNT_W'(v);
    endfunction

    // Value a field takes for a drive that is absent
    function automatic logic [CNT_W-1:0] absent_count(input field_e fld);
        case (fld)
            FLD_ADDR: return CNT_W'(ADDR_MIN);
            FLD_DATA: return CNT_W'(DATA_MIN);
            default:  return CNT_W'(REC_MIN);
        endcase
    endfunction

endpackage

// File: rtl/pio_tc_divider.sv
// Module: restoring divider by a fixed constant, one quotient bit per clock.
// A one-cycle go while idle loads the dividend. NUM_W cycles later fin pulses
// for one clock with the quotient on quo, which then holds until the next go.
// Assumes DIVISOR >= 2. A go that arrives while a division runs is dropped.
module pio_tc_divider #(
    parameter int NUM_W   = 19,
    parameter int DIVISOR = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    output logic             fin,
    output logic [NUM_W-1:0] quo
);
    localparam int REM_W = $clog2(DIVISOR);
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam logic [REM_W:0] DEN = (REM_W + 1)'(DIVISOR);

    logic [REM_W-1:0] rem_q;
    logic [CNT_W-1:0] left_q;
    logic             run_q;
    logic [REM_W:0]   trial;
    logic [REM_W:0]   trial_sub;
    logic             take;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        trial     = {rem_q, quo[NUM_W-1]};
        take      = (trial >= DEN);
        trial_sub = trial - DEN;
    end

    // Division state: shift in a dividend bit and keep the quotient bit each clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            left_q <= '0;
            run_q  <= 1'b0;
            fin    <= 1'b0;
            quo    <= '0;
        end else begin
            fin <= 1'b0;
            if (!run_q) begin
                if (go) begin
                    quo    <= num;
                    rem_q  <= '0;
                    left_q <= CNT_W'(NUM_W);
                    run_q  <= 1'b1;
                end
            end else begin
                rem_q  <= take ? trial_sub[REM_W-1:0] : trial[REM_W-1:0];
                quo    <= {quo[NUM_W-2:0], take};
                left_q <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pio_tc_pack.sv
// Module: packs the clamped clock counts of both drives into register bytes.
// Assumes the counts are already within their clamp ranges.
// Purely combinational.
module pio_tc_pack
    import pio_tc_pkg::*;
#(
    parameter int NDRV = 2
) (
    input  logic                       pfetch,
    input  logic [NDRV-1:0][CNT_W-1:0] addr_cnt,
    input  logic [NDRV-1:0][CNT_W-1:0] data_cnt,
    input  logic [NDRV-1:0][CNT_W-1:0] rec_cnt,
    output logic [NDRV-1:0][7:0]       cyc_byte,
    output logic [7:0]                 misc_byte
);
    logic [CNT_W-1:0] addr_max;

    // One cycle byte per drive: data - 1 in the high nibble, recovery - 2 in the low nibble
    for (genvar g = 0; g < NDRV; g++) begin : g_cyc
        always_comb begin
            cyc_byte[g] = {4'(data_cnt[g] - CNT_W'(1)), 4'(rec_cnt[g] - CNT_W'(2))};
        end
    end

    // Largest address count over all drives
    always_comb begin
        addr_max = addr_cnt[0];
        for (int i = 1; i < NDRV; i++) begin
            if (addr_cnt[i] > addr_max) addr_max = addr_cnt[i];
        end
    end

    // Shared byte: prefetch bit 6, address - 1 in bits 5:4, minimum ready delay (zero field)
    always_comb begin
        misc_byte = {1'b0, pfetch, 2'(addr_max - CNT_W'(1)), 3'b000, 1'b0};
    end

endmodule

// File: rtl/pio_timing_conv.sv
// Module: top of the PIO timing converter.
// A start pulse while idle latches the inputs. Six jobs (three fields for
// each of two drives) then run through one shared divider by 1000. Jobs of an
// absent drive take fixed minimum values without using the divider. At the end
// the packed bytes are registered and done pulses once.
// Assumes time inputs of TIME_W bits in ns and a bus frequency of MHZ_W bits in MHz.
module pio_timing_conv
    import pio_tc_pkg::*;
#(
    parameter int TIME_W  = 10,
    parameter int MHZ_W   = 8,
    parameter int DIVISOR = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pfetch_en,
    input  logic [MHZ_W-1:0]  bus_mhz,
    input  logic [1:0]        drv_present,
    input  logic [TIME_W-1:0] setup_ns0,
    input  logic [TIME_W-1:0] active_ns0,
    input  logic [TIME_W-1:0] cycle_ns0,
    input  logic [TIME_W-1:0] setup_ns1,
    input  logic [TIME_W-1:0] active_ns1,
    input  logic [TIME_W-1:0] cycle_ns1,
    output logic              busy,
    output logic              done,
    output logic [7:0]        cyc_byte0,
    output logic [7:0]        cyc_byte1,
    output logic [7:0]        misc_byte
);
    localparam int NDRV  = 2;
    localparam int NUM_W = TIME_W + MHZ_W + 1;

    // Latched request
    logic [NDRV-1:0][TIME_W-1:0] setup_q;
    logic [NDRV-1:0][TIME_W-1:0] active_q;
    logic [NDRV-1:0][TIME_W-1:0] cycle_q;
    logic [MHZ_W-1:0]            mhz_q;
    logic [NDRV-1:0]             pres_q;
    logic                        pf_q;

    // Job sequencing
    state_e  state_q;
    logic    drv_q;
    field_e  fld_q;
    logic    last_job;

    // Results
    logic [NDRV-1:0][CNT_W-1:0] addr_q;
    logic [NDRV-1:0][CNT_W-1:0] data_q;
    logic [NDRV-1:0][CNT_W-1:0] rec_q;
    logic [CNT_W-1:0]           job_val;

    // Datapath between sequencer, divider and packer
    logic [TIME_W:0]         sa_sum;
    logic [TIME_W:0]         cyc_ext;
    logic [TIME_W-1:0]       rec_ns;
    logic [TIME_W-1:0]       time_sel;
    logic [NUM_W-1:0]        div_num;
    logic                    div_go;
    logic                    div_fin;
    logic [NUM_W-1:0]        div_quo;
    logic [NDRV-1:0][7:0]    pk_cyc;
    logic [7:0]              pk_misc;

    // Recovery in ns for the current drive, floored at zero
    always_comb begin
        sa_sum  = {1'b0, setup_q[drv_q]} + {1'b0, active_q[drv_q]};
        cyc_ext = {1'b0, cycle_q[drv_q]};
        rec_ns  = (cyc_ext > sa_sum) ? TIME_W'(cyc_ext - sa_sum) : '0;
    end

    // Select the time figure of the current job and form the rounded-up dividend
    always_comb begin
        case (fld_q)
            FLD_ADDR: time_sel = setup_q[drv_q];
            FLD_DATA: time_sel = active_q[drv_q];
            default:  time_sel = rec_ns;
        endcase
        div_num = NUM_W'(time_sel) * NUM_W'(mhz_q) + NUM_W'(DIVISOR - 1);
    end

    // Value stored for the current job: a clamped quotient, or the absent-drive default
    always_comb begin
        if (pres_q[drv_q]) job_val = clamp_count(32'(div_quo), fld_q);
        else               job_val = absent_count(fld_q);
        last_job = drv_q && (fld_q == FLD_REC);
    end

    pio_tc_divider #(
        .NUM_W   (NUM_W),
        .DIVISOR (DIVISOR)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .fin   (div_fin),
        .quo   (div_quo)
    );

    pio_tc_pack #(
        .NDRV (NDRV)
    ) u_pack (
        .pfetch    (pf_q),
        .addr_cnt  (addr_q),
        .data_cnt  (data_q),
        .rec_cnt   (rec_q),
        .cyc_byte  (pk_cyc),
        .misc_byte (pk_misc)
    );

    // Sequencer: accept a request, walk through the jobs, store the results, publish the bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            drv_q     <= 1'b0;
            fld_q     <= FLD_ADDR;
            div_go    <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b0;
            setup_q   <= '0;
            active_q  <= '0;
            cycle_q   <= '0;
            mhz_q     <= '0;
            pres_q    <= '0;
            pf_q      <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
            rec_q     <= '0;
            cyc_byte0 <= '0;
            cyc_byte1 <= '0;
            misc_byte <= '0;
        end else begin
            done   <= 1'b0;
            div_go <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        setup_q  <= {setup_ns1, setup_ns0};
                        active_q <= {active_ns1, active_ns0};
                        cycle_q  <= {cycle_ns1, cycle_ns0};
                        mhz_q    <= bus_mhz;
                        pres_q   <= drv_present;
                        pf_q     <= pfetch_en;
                        drv_q    <= 1'b0;
                        fld_q    <= FLD_ADDR;
                        busy     <= 1'b1;
                        state_q  <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (pres_q[drv_q]) begin
                        div_go  <= 1'b1;
                        state_q <= ST_WAIT;
                    end else begin
                        case (fld_q)
                            FLD_ADDR: addr_q[drv_q] <= job_val;
                            FLD_DATA: data_q[drv_q] <= job_val;
                            default:  rec_q[drv_q]  <= job_val;
                        endcase
                        if (last_job) state_q <= ST_FINISH;
                        else if (fld_q == FLD_REC) begin
                            drv_q <= 1'b1;
                            fld_q <= FLD_ADDR;
                        end else fld_q <= field_e'(fld_q + 2'd1);
                    end
                end
                ST_WAIT: begin
                    if (div_fin) begin
                        case (fld_q)
                            FLD_ADDR: addr_q[drv_q] <= job_val;
                            FLD_DATA: data_q[drv_q] <= job_val;
                            default:  rec_q[drv_q]  <= job_val;
                        endcase
                        if (last_job) state_q <= ST_FINISH;
                        else begin
                            state_q <= ST_ISSUE;
                            if (fld_q == FLD_REC) begin
                                drv_q <= 1'b1;
                                fld_q <= FLD_ADDR;
                            end else fld_q <= field_e'(fld_q + 2'd1);
                        end
                    end
                end
                default: begin
                    cyc_byte0 <= pk_cyc[0];
                    cyc_byte1 <= pk_cyc[1];
                    misc_byte <= pk_misc;
                    done      <= 1'b1;
                    busy      <= 1'b0;
                    state_q   <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/pio_tc_chk.sv
// Module: assertion checker for pio_timing_conv, attached by bind.
// Watches the handshake, the hold behaviour of the outputs and the absent-drive result.
module pio_tc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [1:0] pres_q,
    input logic [7:0] cyc_byte0,
    input logic [7:0] cyc_byte1,
    input logic [7:0] misc_byte
);
    // R8: done lasts exactly one clock
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: busy has dropped by the cycle in which done is high
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: the output bytes hold except in a done cycle
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(cyc_byte0) && $stable(cyc_byte1) && $stable(misc_byte)));

    // R8: a start taken while idle raises busy on the next clock
    a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R4: an absent drive 0 yields a zero cycle byte
    a_r4_absent0: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pres_q[0]) |-> (cyc_byte0 == 8'h00));

    // R4: an absent drive 1 yields a zero cycle byte
    a_r4_absent1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pres_q[1]) |-> (cyc_byte1 == 8'h00));

endmodule

bind pio_timing_conv pio_tc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .pres_q    (pres_q),
    .cyc_byte0 (cyc_byte0),
    .cyc_byte1 (cyc_byte1),
    .misc_byte (misc_byte)
);

// File: tb/tb_pio_timing_conv.sv
// Scoreboard bench: the driver task computes expected bytes from the
// requirements and queues them; the monitor pops and compares on each done.
module tb_pio_timing_conv;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       pfetch_en = 1'b0;
    logic [7:0] bus_mhz = '0;
    logic [1:0] drv_present = '0;
    logic [9:0] setup_ns0 = '0, active_ns0 = '0, cycle_ns0 = '0;
    logic [9:0] setup_ns1 = '0, active_ns1 = '0, cycle_ns1 = '0;
    logic       busy, done;
    logic [7:0] cyc_byte0, cyc_byte1, misc_byte;

    typedef struct {
        string      tag;
        logic [7:0] c0;
        logic [7:0] c1;
        logic [7:0] m;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    int   pend   = 0;
    int   dones  = 0;
    int   cycles = 0;

    always #2.5 clk = ~clk;

    pio_timing_conv dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pfetch_en(pfetch_en),
        .bus_mhz(bus_mhz), .drv_present(drv_present),
        .setup_ns0(setup_ns0), .active_ns0(active_ns0), .cycle_ns0(cycle_ns0),
        .setup_ns1(setup_ns1), .active_ns1(active_ns1), .cycle_ns1(cycle_ns1),
        .busy(busy), .done(done),
        .cyc_byte0(cyc_byte0), .cyc_byte1(cyc_byte1), .misc_byte(misc_byte)
    );

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Rounded-up clock count (R1) clamped into [lo, hi] (R3)
    function automatic int conv(input int t, input int mhz, input int lo, input int hi);
        int v;
        v = (t * mhz + 999) / 1000;
        if (v < lo) v = lo;
        if (v > hi) v = hi;
        return v;
    endfunction

    // Expected counts of one drive: R2 recovery, R3 clamps, R4 absent defaults
    task automatic drive_model(input bit pres, input int s, input int a, input int c,
                               input int mhz, output int ad, output int dt, output int rc);
        int r;
        r = c - s - a;
        if (r < 0) r = 0;
        if (!pres) begin ad = 1; dt = 1; rc = 2; end
        else begin
            ad = conv(s, mhz, 1, 4);
            dt = conv(a, mhz, 1, 16);
            rc = conv(r, mhz, 2, 17);
        end
    endtask

    // Driver: queue the expected bytes (R5, R6, R7), pulse start, wait for the result
    task automatic run_case(input string tag, input bit pf, input int mhz, input bit [1:0] pres,
                            input int s0, input int a0, input int c0,
                            input int s1, input int a1, input int c1, input bit poke);
        exp_t e;
        int ad0, dt0, rc0, ad1, dt1, rc1, ax, wait_n;
        drive_model(pres[0], s0, a0, c0, mhz, ad0, dt0, rc0);
        drive_model(pres[1], s1, a1, c1, mhz, ad1, dt1, rc1);
        ax = (ad0 > ad1) ? ad0 : ad1;
        e.tag = tag;
        e.c0 = 8'(((dt0 - 1) << 4) | (rc0 - 2));
        e.c1 = 8'(((dt1 - 1) << 4) | (rc1 - 2));
        e.m  = 8'((pf ? 8'h40 : 8'h00) | ((ax - 1) << 4));
        sb.push_back(e);
        pend++;
        @(negedge clk);
        pfetch_en = pf; bus_mhz = 8'(mhz); drv_present = pres;
        setup_ns0 = 10'(s0); active_ns0 = 10'(a0); cycle_ns0 = 10'(c0);
        setup_ns1 = 10'(s1); active_ns1 = 10'(a1); cycle_ns1 = 10'(c1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R8 busy after start"}, int'(busy), 1);
        if (poke) begin
            // R9: new inputs plus a second start while busy must change nothing
            repeat (5) @(negedge clk);
            bus_mhz = 8'd255; drv_present = 2'b11; pfetch_en = ~pf;
            setup_ns0 = 10'd1000; active_ns0 = 10'd1000; cycle_ns0 = 10'd1023;
            setup_ns1 = 10'd1000; active_ns1 = 10'd1000; cycle_ns1 = 10'd1023;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_n = 0;
        while (pend != 0 && wait_n < 2000) begin
            @(negedge clk);
            wait_n++;
        end
    endtask

    // Monitor: compare every result with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            dones++;
            if (sb.size() == 0) begin
                check("R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " R6 cyc_byte0"}, int'(cyc_byte0), int'(e.c0));
                check({e.tag, " R6 cyc_byte1"}, int'(cyc_byte1), int'(e.c1));
                check({e.tag, " R7 misc_byte"}, int'(misc_byte), int'(e.m));
                pend--;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int d0;
        repeat (4) @(negedge clk);
        // R10: reset state
        check("R10 busy", int'(busy), 0);
        check("R10 done", int'(done), 0);
        check("R10 bytes", int'({cyc_byte0, cyc_byte1, misc_byte}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R5 R6 R7: slow mode on drive 0, fast mode on drive 1, 33 MHz, prefetch on
        run_case("R1 mixed modes", 1'b1, 33, 2'b11, 70, 165, 600, 30, 80, 180, 1'b0);
        // R5: drive 1 has the larger address count
        run_case("R5 max address", 1'b0, 66, 2'b11, 25, 70, 120, 60, 100, 300, 1'b0);
        // R1: exact multiple of 1000 (200 ns at 5 MHz = 1 clk) and one ns above it
        run_case("R1 exact multiple", 1'b0, 5, 2'b11, 200, 400, 1000, 201, 401, 1002, 1'b0);
        // R2: cycle shorter than setup + active gives the recovery minimum
        run_case("R2 negative recovery", 1'b1, 40, 2'b11, 30, 80, 50, 20, 30, 50, 1'b0);
        // R3: upper clamps at 255 MHz with long times
        run_case("R3 upper clamps", 1'b0, 255, 2'b11, 1000, 1000, 1023, 300, 900, 1023, 1'b0);
        // R3: lower clamps with zero times
        run_case("R3 lower clamps", 1'b1, 100, 2'b11, 0, 0, 0, 0, 5, 5, 1'b0);
        // R4: drive 1 absent with large figures on its inputs
        run_case("R4 drive1 absent", 1'b1, 33, 2'b01, 30, 80, 180, 1000, 1000, 1023, 1'b0);
        // R4: drive 0 absent
        run_case("R4 drive0 absent", 1'b0, 50, 2'b10, 900, 900, 1000, 50, 120, 400, 1'b0);
        // R4: both absent
        run_case("R4 both absent", 1'b0, 200, 2'b00, 500, 500, 1023, 500, 500, 1023, 1'b0);
        // R9: second start with other inputs while busy
        d0 = dones;
        run_case("R9 start while busy", 1'b1, 33, 2'b11, 70, 165, 600, 30, 80, 180, 1'b1);
        repeat (200) @(negedge clk);
        check("R9 single done", dones - d0, 1);
        // R8: outputs hold while idle
        check("R8 hold c0", int'(cyc_byte0), 8'h5B);
        check("R8 idle busy", int'(busy), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule